// File: doc/BRIEF.md
# Anti-diagonal wavefront stencil sweeper

The sweeper performs one in-place Gauss-Seidel relaxation step over a square n×n tile. The tile sits in a local RAM that has a one-element frame of fixed neighbour values around it. Each interior element is replaced by the truncated mean of its four neighbours: the sum of up, down, left and right, shifted right by two, in unsigned 16-bit fixed point. Because the array is updated in place, the up and left neighbours already carry this step's values, while the right and down neighbours still carry the previous step's values.

The block visits elements one anti-diagonal at a time, so that it can start one element per cycle even though neighbours depend on each other. It drives a read request carrying the centre address. The RAM returns the four neighbours in the same cycle. A fixed-latency pipeline then writes the result back. When a diagonal is long enough to cover the pipeline latency, the next diagonal follows it with no gap. After a shorter diagonal, the walker holds issue until the pipeline has drained. A one-cycle done pulse marks the end of the sweep.

Top module: `wavefront_sweeper`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, rd_en, wr_en and done are all low.
- R2: Elements are processed along anti-diagonals d = 1 … 2n-1, using interior coordinates (row i, column j), each running from 0 to n-1.
  - For d ≤ n, a diagonal starts at (d-1, 0). For d > n, it starts at (n-1, d-n).
  - Each following element has its row decreased by one and its column increased by one. The diagonal ends when the row would go below 0 or the column would reach n.
  - Writes leave the block in exactly this order.
- R3: Interior element (i, j) is read and written at RAM row i+1, column j+1. The frame rows and columns 0 and n+1 are never written.
- R4: The written value is (up + down + left + right) >> 2, computed without overflow and truncated to 16 bits, where up is row-1, down is row+1, left is column-1 and right is column+1. The final tile therefore equals a row-major in-place sweep.
- R5: The write for an element whose read request is driven in cycle t is presented in cycle t+LAT-1, carrying the same RAM address.
- R6: After the last element of diagonal d (d < 2n-1), the first element of d+1 is requested in the next cycle if LAT < length(d). Otherwise it is requested exactly LAT cycles after that last element. Here length(d) is d for d ≤ n and 2n-d otherwise.
- R7: done is high for exactly one cycle per sweep: LAT cycles after the final read request, which is one cycle after the final write.
- R8: A start pulse that arrives while a sweep is in progress has no effect.
- R9: A start with tile_n equal to 0 or greater than N_MAX is ignored: no access is made and done is not raised.
- R10: No read request is made in a cycle in which its up or left neighbour is still being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle |
| tile_n | input | $clog2(N_MAX+1) | Tile edge length n, captured at start |
| rd_en | output | 1 | Read request for the centre address below |
| rd_row | output | $clog2(N_MAX+2) | RAM row of the centre element |
| rd_col | output | $clog2(N_MAX+2) | RAM column of the centre element |
| nb_up | input | DW | RAM word at (rd_row-1, rd_col), same cycle |
| nb_down | input | DW | RAM word at (rd_row+1, rd_col), same cycle |
| nb_left | input | DW | RAM word at (rd_row, rd_col-1), same cycle |
| nb_right | input | DW | RAM word at (rd_row, rd_col+1), same cycle |
| wr_en | output | 1 | Write strobe |
| wr_row | output | $clog2(N_MAX+2) | RAM row of the write |
| wr_col | output | $clog2(N_MAX+2) | RAM column of the write |
| wr_data | output | DW | Updated element value |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench builds the block with N_MAX = 8, LAT = 3 and DW = 16 and runs tiles of size 1, 2, 3, 4, 5 and 8.

With these values, tiles of size 3 and below are stalled after every diagonal. Size 4 has a single back-to-back transition, and size 8 has a long collapsed middle run between stalled leading and trailing diagonals. A read-before-write error at either edge of that run would therefore show up as a wrong value.

The total sweep time is predicted from the diagonal lengths. The out-of-range sizes 0 and 9 exercise the rejected-start path.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic [1:0] {
        WF_IDLE,
        WF_RUN,
        WF_FINISH
    } wf_state_e;

endpackage

// File: rtl/wf_walker.sv
module wf_walker
    import wf_pkg::*;
#(
    parameter  int N_MAX = 8,
    parameter  int LAT   = 3,
    localparam int NW    = $clog2(N_MAX + 1),
    localparam int IW    = $clog2(N_MAX),
    localparam int DD    = $clog2(2 * N_MAX + 1),
    localparam int AW    = $clog2(N_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] tile_n,
    input  logic          pipe_empty,
    output logic          issue,
    output logic [AW-1:0] iss_row,
    output logic [AW-1:0] iss_col,
    output logic          done
);

    localparam int unsigned LATU = LAT;

    typedef struct packed {
        wf_state_e     st;
        logic [NW-1:0] n;
        logic [DD-1:0] d;
        logic [IW-1:0] i;
        logic [IW-1:0] j;
        logic          hold;
    } walk_t;

    walk_t w_d, w_q;

    logic [DD-1:0] nx, len, dn;
    logic          last, stall, fire, start_ok;

    always_comb begin
        w_d      = w_q;
        issue    = 1'b0;
        done     = 1'b0;
        nx       = DD'(w_q.n);
        len      = (w_q.d <= nx) ? w_q.d : ((nx << 1) - w_q.d);
        dn       = w_q.d + DD'(1);
        last     = (w_q.i == '0) || (NW'(w_q.j) + NW'(1) == w_q.n);
        stall    = (32'(len) <= LATU);
        fire     = (w_q.st == WF_RUN) && (!w_q.hold || pipe_empty);
        start_ok = start && (tile_n != '0) && (tile_n <= NW'(N_MAX));

        case (w_q.st)
            WF_IDLE: begin
                if (start_ok) begin
                    w_d.st   = WF_RUN;
                    w_d.n    = tile_n;
                    w_d.d    = DD'(1);
                    w_d.i    = '0;
                    w_d.j    = '0;
                    w_d.hold = 1'b0;
                end
            end
            WF_RUN: begin
                if (fire) begin
                    issue    = 1'b1;
                    w_d.hold = 1'b0;
                    if (last) begin
                        if (w_q.d == (nx << 1) - DD'(1)) begin
                            w_d.st = WF_FINISH;
                        end else begin
                            w_d.d    = dn;
                            w_d.hold = stall;
                            if (dn <= nx) begin
                                w_d.i = IW'(w_q.d);
                                w_d.j = '0;
                            end else begin
                                w_d.i = IW'(nx - DD'(1));
                                w_d.j = IW'(dn - nx);
                            end
                        end
                    end else begin
                        w_d.i = w_q.i - IW'(1);
                        w_d.j = w_q.j + IW'(1);
                    end
                end
            end
            WF_FINISH: begin
                if (pipe_empty) begin
                    done   = 1'b1;
                    w_d.st = WF_IDLE;
                end
            end
            default: w_d.st = WF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: WF_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign iss_row = AW'(w_q.i) + AW'(1);
    assign iss_col = AW'(w_q.j) + AW'(1);

endmodule

// File: rtl/wf_pipe.sv
module wf_pipe #(
    parameter int DW  = 16,
    parameter int AW  = 4,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] row,
    input  logic [AW-1:0] col,
    input  logic [DW-1:0] up,
    input  logic [DW-1:0] down,
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] right,
    output logic          wr_en,
    output logic [AW-1:0] wr_row,
    output logic [AW-1:0] wr_col,
    output logic [DW-1:0] wr_data,
    output logic          empty
);

    localparam int ST = LAT - 1;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] r;
        logic [AW-1:0] c;
        logic [DW-1:0] x;
    } stg_t;

    stg_t [ST-1:0] pipe_d, pipe_q;
    logic [DW+1:0] sum;
    logic [ST-1:0] occ;

    always_comb begin
        sum = {2'b00, up} + {2'b00, down} + {2'b00, left} + {2'b00, right};
        pipe_d[0] = '{v: fire, r: row, c: col, x: sum[DW+1:2]};
        for (int k = 1; k < ST; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar g = 0; g < ST; g++) begin : g_occ
        assign occ[g] = pipe_q[g].v;
    end

    assign empty   = (occ == '0);
    assign wr_en   = pipe_q[ST-1].v;
    assign wr_row  = pipe_q[ST-1].r;
    assign wr_col  = pipe_q[ST-1].c;
    assign wr_data = pipe_q[ST-1].x;

endmodule

// File: rtl/wavefront_sweeper.sv
module wavefront_sweeper #(
    parameter  int N_MAX = 8,
    parameter  int LAT   = 3,
    parameter  int DW    = 16,
    localparam int NW    = $clog2(N_MAX + 1),
    localparam int AW    = $clog2(N_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] tile_n,
    output logic          rd_en,
    output logic [AW-1:0] rd_row,
    output logic [AW-1:0] rd_col,
    input  logic [DW-1:0] nb_up,
    input  logic [DW-1:0] nb_down,
    input  logic [DW-1:0] nb_left,
    input  logic [DW-1:0] nb_right,
    output logic          wr_en,
    output logic [AW-1:0] wr_row,
    output logic [AW-1:0] wr_col,
    output logic [DW-1:0] wr_data,
    output logic          done
);

    logic pipe_empty;

    wf_walker #(.N_MAX(N_MAX), .LAT(LAT)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tile_n     (tile_n),
        .pipe_empty (pipe_empty),
        .issue      (rd_en),
        .iss_row    (rd_row),
        .iss_col    (rd_col),
        .done       (done)
    );

    wf_pipe #(.DW(DW), .AW(AW), .LAT(LAT)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (rd_en),
        .row     (rd_row),
        .col     (rd_col),
        .up      (nb_up),
        .down    (nb_down),
        .left    (nb_left),
        .right   (nb_right),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .empty   (pipe_empty)
    );

endmodule

// File: rtl/wf_checks.sv
module wf_checks #(
    parameter  int N_MAX = 8,
    localparam int AW    = $clog2(N_MAX + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_row,
    input logic [AW-1:0] rd_col,
    input logic          wr_en,
    input logic [AW-1:0] wr_row,
    input logic [AW-1:0] wr_col,
    input logic          done
);

    // R1: quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_en && !wr_en && !done));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no traffic left when done is raised
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && !wr_en));

    // R3: reads stay inside the interior
    a_r3_read_interior: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_row >= AW'(1) && rd_row <= AW'(N_MAX) &&
                   rd_col >= AW'(1) && rd_col <= AW'(N_MAX)));

    // R3: writes never touch the frame
    a_r3_write_interior: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row >= AW'(1) && wr_row <= AW'(N_MAX) &&
                   wr_col >= AW'(1) && wr_col <= AW'(N_MAX)));

    // R10: never read a neighbour that is being written this cycle
    a_r10_no_stale_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |->
            !((wr_row + AW'(1) == rd_row && wr_col == rd_col) ||
              (wr_row == rd_row && wr_col + AW'(1) == rd_col)));

endmodule

bind wavefront_sweeper wf_checks #(.N_MAX(N_MAX)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_row (rd_row),
    .rd_col (rd_col),
    .wr_en  (wr_en),
    .wr_row (wr_row),
    .wr_col (wr_col),
    .done   (done)
);

// File: tb/wavefront_sweeper_test.sv
module wavefront_sweeper_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_MAX = 8;
    localparam int LAT   = 3;
    localparam int DW    = 16;
    localparam int NW    = $clog2(N_MAX + 1);
    localparam int AW    = $clog2(N_MAX + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] tile_n = '0;
    logic          rd_en, wr_en, done;
    logic [AW-1:0] rd_row, rd_col, wr_row, wr_col;
    logic [DW-1:0] nb_up, nb_down, nb_left, nb_right, wr_data;

    logic [DW-1:0] mem [0:N_MAX+1][0:N_MAX+1];
    logic          load = 1'b0;
    int            seed_q = 0;
    int            cyc = 0;

    typedef struct {
        int            r;
        int            c;
        logic [DW-1:0] v;
    } item_t;

    item_t exp_q[$];
    int    iss_q[$];

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int done_cnt = 0, done_cyc = 0, wr_cnt = 0, last_wr_cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wavefront_sweeper #(.N_MAX(N_MAX), .LAT(LAT), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tile_n(tile_n),
        .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
        .nb_up(nb_up), .nb_down(nb_down), .nb_left(nb_left), .nb_right(nb_right),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .done(done)
    );

    function automatic logic [DW-1:0] pattern(int seed, int r, int c);
        return DW'((seed * 7919 + r * 1237 + c * 613 + r * c * 29) % 65536);
    endfunction

    assign nb_up    = mem[int'(rd_row) - 1][int'(rd_col)];
    assign nb_down  = mem[int'(rd_row) + 1][int'(rd_col)];
    assign nb_left  = mem[int'(rd_row)][int'(rd_col) - 1];
    assign nb_right = mem[int'(rd_row)][int'(rd_col) + 1];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load) begin
            for (int r = 0; r <= N_MAX + 1; r++)
                for (int c = 0; c <= N_MAX + 1; c++)
                    mem[r][c] <= pattern(seed_q, r, c);
        end else if (wr_en) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    // monitor: pops the scoreboard as writes appear
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) iss_q.push_back(cyc);
            if (wr_en) begin
                item_t e;
                wr_cnt++;
                last_wr_cyc = cyc;
                mon_checks++;
                if (exp_q.size() == 0) begin
                    mon_errors++;
                    $display("FAIL R2 unexpected write actual (%0d,%0d) expected none", wr_row, wr_col);
                end else begin
                    e = exp_q.pop_front();
                    if (int'(wr_row) != e.r || int'(wr_col) != e.c) begin
                        mon_errors++;
                        $display("FAIL R2 write address actual (%0d,%0d) expected (%0d,%0d)",
                                 wr_row, wr_col, e.r, e.c);
                    end
                    mon_checks++;
                    if (wr_data !== e.v) begin
                        mon_errors++;
                        $display("FAIL R4 value at (%0d,%0d) actual %0d expected %0d",
                                 e.r, e.c, wr_data, e.v);
                    end
                end
                mon_checks++;
                if (iss_q.size() == 0) begin
                    mon_errors++;
                    $display("FAIL R5 write with no read actual none expected a read");
                end else begin
                    int t;
                    t = iss_q.pop_front();
                    if (cyc - t != LAT - 1) begin
                        mon_errors++;
                        $display("FAIL R5 latency actual %0d expected %0d", cyc - t, LAT - 1);
                    end
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_tile(input int n, input int seed, input bit again);
        int g [0:N_MAX+1][0:N_MAX+1];
        int nst, expc, d0, t0, waited;
        seed_q = seed;
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        for (int r = 0; r <= N_MAX + 1; r++)
            for (int c = 0; c <= N_MAX + 1; c++)
                g[r][c] = int'(pattern(seed, r, c));
        for (int i = 1; i <= n; i++)
            for (int j = 1; j <= n; j++)
                g[i][j] = ((g[i-1][j] + g[i+1][j] + g[i][j-1] + g[i][j+1]) >> 2) & 16'hFFFF;
        nst = 0;
        for (int d = 1; d <= 2 * n - 1; d++) begin
            int r, c, len;
            r = (d <= n) ? d - 1 : n - 1;
            c = (d <= n) ? 0 : d - n;
            len = (d <= n) ? d : 2 * n - d;
            if (d < 2 * n - 1 && LAT >= len) nst++;
            while (r >= 0 && c < n) begin
                item_t it;
                it.r = r + 1;
                it.c = c + 1;
                it.v = DW'(g[r+1][c+1]);
                exp_q.push_back(it);
                r--;
                c++;
            end
        end
        expc = n * n + nst * (LAT - 1) + LAT;
        d0 = done_cnt;
        @(negedge clk);
        tile_n = NW'(n);
        start  = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        if (again) begin
            repeat (3) @(negedge clk);
            tile_n = NW'(2);
            start  = 1'b1;   // R8: must be ignored while busy
            @(negedge clk);
            start = 1'b0;
            tile_n = NW'(n);
        end
        waited = 0;
        while (done_cnt == d0 && waited < 5000) begin
            tick();
            waited++;
        end
        check(done_cnt != d0, "R7 done seen", done_cnt - d0, 1);
        repeat (LAT + 4) tick();
        check(done_cnt == d0 + 1, "R7 done pulse count", done_cnt - d0, 1);
        check(done_cyc - t0 == expc, "R6 sweep length in cycles", done_cyc - t0, expc);
        check(done_cyc - last_wr_cyc == 1, "R7 done after final write", done_cyc - last_wr_cyc, 1);
        check(exp_q.size() == 0, again ? "R8 writes remaining" : "R2 writes remaining",
              exp_q.size(), 0);
        for (int r = 0; r <= N_MAX + 1; r++)
            for (int c = 0; c <= N_MAX + 1; c++) begin
                bit inner;
                inner = (r >= 1 && r <= n && c >= 1 && c <= n);
                if (int'(mem[r][c]) != g[r][c]) begin
                    check(1'b0, inner ? "R4 final tile" : "R3 frame untouched",
                          int'(mem[r][c]), g[r][c]);
                end
            end
        check(1'b1, "R3 frame scan", 0, 0);
        exp_q.delete();
        iss_q.delete();
    endtask

    task automatic bad_start(input int n);
        int d0, w0;
        d0 = done_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        tile_n = NW'(n);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) tick();
        check(done_cnt == d0, "R9 no done for bad size", done_cnt - d0, 0);
        check(wr_cnt == w0, "R9 no writes for bad size", wr_cnt - w0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check(!rd_en && !wr_en && !done, "R1 outputs in reset", {rd_en, wr_en, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!rd_en && !wr_en && !done, "R1 outputs after reset", {rd_en, wr_en, done}, 0);
        run_tile(1, 3, 1'b0);
        run_tile(2, 11, 1'b0);
        run_tile(3, 5, 1'b0);
        run_tile(4, 21, 1'b0);
        run_tile(5, 8, 1'b1);
        run_tile(8, 42, 1'b0);
        bad_start(0);
        bad_start(9);
        run_tile(8, 77, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule